// File: doc/BRIEF.md
# Stepper Driver Setting Commit Controller

This block keeps two copies of the settings for a stepper motor pulse driver: a staged copy that a front end fills, and an active copy that the pulse generator and output stage use. The settings are pulse width, pulse count, rotation direction, coil current setting and output enable. An active enable of 0 puts the outputs in high impedance. An active enable of 1 lets them conduct. The front end presents a full set of values and pulses a latch strobe. A select line chosen with the strobe marks the set as either initial data or standard data. Initial data goes straight to the active copy. Standard data waits for the next frame.

A rising edge on the frame sync input starts two timed waits in a row. Each wait lasts a programmable number of clock cycles. The end of the first wait is stage point 1 and the end of the second is stage point 2. Each is shown on its own one-cycle output pulse, so a downstream pulse generator can start at stage point 2.

Each field moves to the active copy at one of the two points, and the choice depends on the enable transition. When the driver is being switched on (active enable 0, staged enable 1), current and enable commit at stage point 1, and the motion fields commit at stage point 2. In every other case all five fields commit together at stage point 2.

Top module: `stepper_shadow_commit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every active output is 0 (enable 0, so the outputs are high impedance) and both stage pulses are 0.
- R2: A rising edge of `frame_sync_i` seen at clock edge E0 makes `stage1_o` high for exactly one cycle, starting at edge E0+S. S is the start wait length captured at E0, and a length of 0 is treated as 1.
- R3: `stage2_o` goes high for exactly one cycle, starting D edges after stage point 1. D is the drive wait length captured at E0, and 0 is treated as 1. The two stage pulses are never high together.
- R4: If the active enable is 0 and the staged enable is 1 at stage point 1, the current and enable fields commit at that edge. Pulse width, count and direction commit at stage point 2.
- R5: If the active enable is 1, or the staged enable is 0, stage point 1 changes nothing. All five fields commit at stage point 2.
- R6: A latch strobe with `init_sel_i`=1 copies the write inputs to the active outputs at the same clock edge, with no frame needed. It also cancels any commit still waiting for a frame.
- R7: If no standard latch has occurred since the last commit, stage points 1 and 2 leave every active output unchanged.
- R8: A new rising frame sync edge during a sequence restarts the start wait from that edge. Staged values that have not yet been committed are kept and commit in the restarted frame.
- R9: The wait lengths are captured only at the frame sync edge. Changes to `start_wait_i` or `drive_wait_i` during a sequence do not move the stage points.
- R10: If a standard latch arrives after an early stage-1 commit and before stage point 2, all five fields commit from the newer values at stage point 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync_i | input | 1 | Frame sync; a rising edge starts the wait sequence |
| latch_i | input | 1 | One-cycle strobe that captures the write inputs |
| init_sel_i | input | 1 | With the strobe: 1 = initial data (applied at once), 0 = standard data (staged) |
| wr_pw_i | input | 8 | Pulse width to write |
| wr_cnt_i | input | 10 | Pulse count to write |
| wr_dir_i | input | 1 | Rotation direction to write |
| wr_cur_i | input | 4 | Current setting to write |
| wr_ena_i | input | 1 | Output enable to write |
| start_wait_i | input | 16 | Start wait length in clock cycles |
| drive_wait_i | input | 16 | Drive wait length in clock cycles |
| act_pw_o | output | 8 | Active pulse width |
| act_cnt_o | output | 10 | Active pulse count |
| act_dir_o | output | 1 | Active rotation direction |
| act_cur_o | output | 4 | Active current setting |
| act_ena_o | output | 1 | Active enable (0 = outputs high impedance) |
| stage1_o | output | 1 | One-cycle pulse at the end of the start wait |
| stage2_o | output | 1 | One-cycle pulse at the end of the drive wait; pulse output may begin |

## Verification
The bench drives every input on the falling edge, so the edge that samples a frame sync rise or a latch can be counted exactly. An initial-data latch must show on the active outputs at the falling edge right after the capturing rising edge. Stage point 1 is due S rising edges after the edge that saw the frame sync rise, and stage point 2 is due D edges after that. The bench waits exactly those counts of falling edges before it samples the stage pulses and the active fields. It then samples one cycle later to confirm that each pulse has dropped.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    parameter int PW_W   = 8;
    parameter int CNT_W  = 10;
    parameter int CUR_W  = 4;
    parameter int WAIT_W = 16;

    typedef struct packed {
        logic [PW_W-1:0]  pw;
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic [CUR_W-1:0] cur;
        logic             ena;
    } drv_set_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_DRIVE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ssc_frame_seq.sv
module ssc_frame_seq
    import ssc_pkg::*;
#(
    parameter int LEN_W = WAIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [LEN_W-1:0] start_len_i,
    input  logic [LEN_W-1:0] drive_len_i,
    output logic             fire1_o,
    output logic             fire2_o,
    output logic             pt1_o,
    output logic             pt2_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] drive_len;
        logic             sync_prev;
        logic             pt1;
        logic             pt2;
    } seq_t;

    seq_t seq_q, seq_d;

    function automatic logic [LEN_W-1:0] at_least_one(input logic [LEN_W-1:0] v);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

    always_comb begin
        seq_d           = seq_q;
        seq_d.sync_prev = sync_i;
        seq_d.pt1       = 1'b0;
        seq_d.pt2       = 1'b0;
        fire1_o         = 1'b0;
        fire2_o         = 1'b0;
        if (sync_i && !seq_q.sync_prev) begin
            seq_d.state     = SEQ_START;
            seq_d.cnt       = at_least_one(start_len_i);
            seq_d.drive_len = at_least_one(drive_len_i);
        end else begin
            unique case (seq_q.state)
                SEQ_START: begin
                    if (seq_q.cnt <= LEN_W'(1)) begin
                        fire1_o     = 1'b1;
                        seq_d.pt1   = 1'b1;
                        seq_d.state = SEQ_DRIVE;
                        seq_d.cnt   = seq_q.drive_len;
                    end else begin
                        seq_d.cnt = seq_q.cnt - LEN_W'(1);
                    end
                end
                SEQ_DRIVE: begin
                    if (seq_q.cnt <= LEN_W'(1)) begin
                        fire2_o     = 1'b1;
                        seq_d.pt2   = 1'b1;
                        seq_d.state = SEQ_IDLE;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt - LEN_W'(1);
                    end
                end
                default: begin
                    seq_d.state = SEQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pt1_o = seq_q.pt1;
    assign pt2_o = seq_q.pt2;
endmodule

// File: rtl/ssc_shadow.sv
module ssc_shadow
    import ssc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     latch_i,
    input  logic     init_i,
    input  drv_set_t wr_i,
    input  logic     early_go_i,
    input  logic     late_go_i,
    output drv_set_t sh_o,
    output logic     pending_o,
    output logic     early_done_o
);
    typedef struct packed {
        drv_set_t sh;
        logic     pending;
        logic     early_done;
    } shd_t;

    shd_t shd_q, shd_d;

    always_comb begin
        shd_d = shd_q;
        if (latch_i) begin
            shd_d.sh         = wr_i;
            shd_d.pending    = !init_i;
            shd_d.early_done = 1'b0;
        end else if (late_go_i) begin
            shd_d.pending    = 1'b0;
            shd_d.early_done = 1'b0;
        end else if (early_go_i) begin
            shd_d.early_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else begin
            shd_q <= shd_d;
        end
    end

    assign sh_o         = shd_q.sh;
    assign pending_o    = shd_q.pending;
    assign early_done_o = shd_q.early_done;
endmodule

// File: rtl/ssc_commit.sv
module ssc_commit
    import ssc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fire1_i,
    input  logic     fire2_i,
    input  drv_set_t sh_i,
    input  logic     pending_i,
    input  logic     early_done_i,
    input  logic     latch_i,
    input  logic     init_i,
    input  drv_set_t wr_i,
    output drv_set_t act_o,
    output logic     early_go_o,
    output logic     late_go_o
);
    drv_set_t act_q, act_d;

    always_comb begin
        act_d      = act_q;
        early_go_o = fire1_i && pending_i && !act_q.ena && sh_i.ena;
        late_go_o  = fire2_i && pending_i;
        if (latch_i && init_i) begin
            act_d = wr_i;
        end else begin
            if (early_go_o) begin
                act_d.cur = sh_i.cur;
                act_d.ena = sh_i.ena;
            end
            if (late_go_o) begin
                act_d.pw  = sh_i.pw;
                act_d.cnt = sh_i.cnt;
                act_d.dir = sh_i.dir;
                if (!early_done_i) begin
                    act_d.cur = sh_i.cur;
                    act_d.ena = sh_i.ena;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/stepper_shadow_commit.sv
module stepper_shadow_commit
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync_i,
    input  logic              latch_i,
    input  logic              init_sel_i,
    input  logic [PW_W-1:0]   wr_pw_i,
    input  logic [CNT_W-1:0]  wr_cnt_i,
    input  logic              wr_dir_i,
    input  logic [CUR_W-1:0]  wr_cur_i,
    input  logic              wr_ena_i,
    input  logic [WAIT_W-1:0] start_wait_i,
    input  logic [WAIT_W-1:0] drive_wait_i,
    output logic [PW_W-1:0]   act_pw_o,
    output logic [CNT_W-1:0]  act_cnt_o,
    output logic              act_dir_o,
    output logic [CUR_W-1:0]  act_cur_o,
    output logic              act_ena_o,
    output logic              stage1_o,
    output logic              stage2_o
);
    drv_set_t wr_set, sh_set, act_set;
    logic     fire1, fire2, pending, early_done, early_go, late_go;

    assign wr_set = '{pw: wr_pw_i, cnt: wr_cnt_i, dir: wr_dir_i,
                      cur: wr_cur_i, ena: wr_ena_i};

    ssc_frame_seq #(.LEN_W(WAIT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (frame_sync_i),
        .start_len_i (start_wait_i),
        .drive_len_i (drive_wait_i),
        .fire1_o     (fire1),
        .fire2_o     (fire2),
        .pt1_o       (stage1_o),
        .pt2_o       (stage2_o)
    );

    ssc_shadow u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_i      (latch_i),
        .init_i       (init_sel_i),
        .wr_i         (wr_set),
        .early_go_i   (early_go),
        .late_go_i    (late_go),
        .sh_o         (sh_set),
        .pending_o    (pending),
        .early_done_o (early_done)
    );

    ssc_commit u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire1_i      (fire1),
        .fire2_i      (fire2),
        .sh_i         (sh_set),
        .pending_i    (pending),
        .early_done_i (early_done),
        .latch_i      (latch_i),
        .init_i       (init_sel_i),
        .wr_i         (wr_set),
        .act_o        (act_set),
        .early_go_o   (early_go),
        .late_go_o    (late_go)
    );

    assign act_pw_o  = act_set.pw;
    assign act_cnt_o = act_set.cnt;
    assign act_dir_o = act_set.dir;
    assign act_cur_o = act_set.cur;
    assign act_ena_o = act_set.ena;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker
    import ssc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             latch_i,
    input logic             init_sel_i,
    input logic [PW_W-1:0]  act_pw_o,
    input logic [CUR_W-1:0] act_cur_o,
    input logic             act_ena_o,
    input logic             stage1_o,
    input logic             stage2_o
);
    // R3: the two points never coincide
    a_r3_points_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(stage1_o && stage2_o));

    // R2: stage point 1 is a single-cycle pulse
    a_r2_pt1_single: assert property (@(posedge clk) disable iff (!rst_n)
        stage1_o |=> !stage1_o);

    // R3: stage point 2 is a single-cycle pulse
    a_r3_pt2_single: assert property (@(posedge clk) disable iff (!rst_n)
        stage2_o |=> !stage2_o);

    // R4: motion fields move only at stage point 2 or on an initial latch
    a_r4_motion_at_pt2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pw_o != $past(act_pw_o)) |-> (stage2_o || $past(latch_i && init_sel_i)));

    // R4: enable switches on only at a stage point or on an initial latch
    a_r4_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_ena_o) |-> (stage1_o || stage2_o || $past(latch_i && init_sel_i)));

    // R5: enable switches off only at stage point 2 or on an initial latch
    a_r5_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_ena_o) |-> (stage2_o || $past(latch_i && init_sel_i)));

    // R5: a current change at stage point 1 comes only with enable turning on
    a_r5_cur_early: assert property (@(posedge clk) disable iff (!rst_n)
        (stage1_o && !$past(latch_i && init_sel_i) && (act_cur_o != $past(act_cur_o)))
            |-> $rose(act_ena_o));
endmodule

bind stepper_shadow_commit ssc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_i    (latch_i),
    .init_sel_i (init_sel_i),
    .act_pw_o   (act_pw_o),
    .act_cur_o  (act_cur_o),
    .act_ena_o  (act_ena_o),
    .stage1_o   (stage1_o),
    .stage2_o   (stage2_o)
);

// File: tb/stepper_shadow_commit_tb.sv
`timescale 1ns/1ps
module stepper_shadow_commit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync_i = 1'b0;
    logic        latch_i = 1'b0;
    logic        init_sel_i = 1'b0;
    logic [7:0]  wr_pw_i = '0;
    logic [9:0]  wr_cnt_i = '0;
    logic        wr_dir_i = 1'b0;
    logic [3:0]  wr_cur_i = '0;
    logic        wr_ena_i = 1'b0;
    logic [15:0] start_wait_i = 16'd3;
    logic [15:0] drive_wait_i = 16'd4;
    logic [7:0]  act_pw_o;
    logic [9:0]  act_cnt_o;
    logic        act_dir_o;
    logic [3:0]  act_cur_o;
    logic        act_ena_o;
    logic        stage1_o;
    logic        stage2_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    stepper_shadow_commit u_dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_act(input string req, input logic [7:0] pw, input logic [9:0] cnt,
                           input logic dir, input logic [3:0] cur, input logic ena);
        chk(req, "pw",  32'(act_pw_o),  32'(pw));
        chk(req, "cnt", 32'(act_cnt_o), 32'(cnt));
        chk(req, "dir", 32'(act_dir_o), 32'(dir));
        chk(req, "cur", 32'(act_cur_o), 32'(cur));
        chk(req, "ena", 32'(act_ena_o), 32'(ena));
    endtask

    // starts and ends at a falling edge
    task automatic do_latch(input logic init, input logic [7:0] pw, input logic [9:0] cnt,
                            input logic dir, input logic [3:0] cur, input logic ena);
        wr_pw_i = pw; wr_cnt_i = cnt; wr_dir_i = dir; wr_cur_i = cur; wr_ena_i = ena;
        init_sel_i = init; latch_i = 1'b1;
        @(negedge clk);
        latch_i = 1'b0; init_sel_i = 1'b0;
    endtask

    // returns at the falling edge after the edge that sees the rise
    task automatic sync_pulse();
        frame_sync_i = 1'b1;
        @(negedge clk);
        frame_sync_i = 1'b0;
    endtask

    task automatic t_reset();
        chk_act("R1", 8'd0, 10'd0, 1'b0, 4'd0, 1'b0);
        chk("R1", "stage1", 32'(stage1_o), 0);
        chk("R1", "stage2", 32'(stage2_o), 0);
    endtask

    task automatic t_enable_on();
        do_latch(1'b0, 8'd5, 10'd7, 1'b1, 4'd9, 1'b1);
        sync_pulse();
        repeat (2) @(negedge clk);
        chk("R2", "stage1 early", 32'(stage1_o), 0);
        @(negedge clk);
        chk("R2", "stage1 due", 32'(stage1_o), 1);
        chk_act("R4", 8'd0, 10'd0, 1'b0, 4'd9, 1'b1);
        repeat (4) @(negedge clk);
        chk("R3", "stage2 due", 32'(stage2_o), 1);
        chk_act("R4", 8'd5, 10'd7, 1'b1, 4'd9, 1'b1);
        @(negedge clk);
        chk("R3", "stage2 drops", 32'(stage2_o), 0);
    endtask

    task automatic t_steady_on();
        do_latch(1'b0, 8'd6, 10'd11, 1'b0, 4'd3, 1'b1);
        sync_pulse();
        repeat (3) @(negedge clk);
        chk_act("R5", 8'd5, 10'd7, 1'b1, 4'd9, 1'b1);
        repeat (4) @(negedge clk);
        chk_act("R5", 8'd6, 10'd11, 1'b0, 4'd3, 1'b1);
    endtask

    task automatic t_disable();
        do_latch(1'b0, 8'd6, 10'd11, 1'b0, 4'd2, 1'b0);
        sync_pulse();
        repeat (3) @(negedge clk);
        chk_act("R5", 8'd6, 10'd11, 1'b0, 4'd3, 1'b1);
        repeat (4) @(negedge clk);
        chk_act("R5", 8'd6, 10'd11, 1'b0, 4'd2, 1'b0);
    endtask

    task automatic t_no_latch();
        sync_pulse();
        repeat (3) @(negedge clk);
        chk("R7", "stage1", 32'(stage1_o), 1);
        chk_act("R7", 8'd6, 10'd11, 1'b0, 4'd2, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7", "stage2", 32'(stage2_o), 1);
        chk_act("R7", 8'd6, 10'd11, 1'b0, 4'd2, 1'b0);
    endtask

    task automatic t_initial();
        do_latch(1'b1, 8'd1, 10'd2, 1'b0, 4'd12, 1'b1);
        chk_act("R6", 8'd1, 10'd2, 1'b0, 4'd12, 1'b1);
        sync_pulse();
        repeat (7) @(negedge clk);
        chk("R6", "stage2", 32'(stage2_o), 1);
        chk_act("R6", 8'd1, 10'd2, 1'b0, 4'd12, 1'b1);
    endtask

    task automatic t_restart();
        do_latch(1'b0, 8'd3, 10'd4, 1'b1, 4'd5, 1'b0);
        sync_pulse();
        repeat (2) @(negedge clk);
        sync_pulse();
        chk("R8", "old stage1 suppressed", 32'(stage1_o), 0);
        repeat (2) @(negedge clk);
        chk("R8", "stage1 not yet", 32'(stage1_o), 0);
        @(negedge clk);
        chk("R8", "stage1 restarted", 32'(stage1_o), 1);
        repeat (4) @(negedge clk);
        chk("R8", "stage2", 32'(stage2_o), 1);
        chk_act("R8", 8'd3, 10'd4, 1'b1, 4'd5, 1'b0);
    endtask

    task automatic t_lengths();
        start_wait_i = 16'd2;
        sync_pulse();
        start_wait_i = 16'd6;
        drive_wait_i = 16'd9;
        repeat (2) @(negedge clk);
        chk("R9", "stage1 at captured length", 32'(stage1_o), 1);
        repeat (4) @(negedge clk);
        chk("R9", "stage2 at captured length", 32'(stage2_o), 1);
        start_wait_i = 16'd0;
        drive_wait_i = 16'd4;
        sync_pulse();
        @(negedge clk);
        chk("R2", "zero length stage1", 32'(stage1_o), 1);
        repeat (4) @(negedge clk);
        chk("R3", "stage2 after zero start", 32'(stage2_o), 1);
        start_wait_i = 16'd3;
    endtask

    task automatic t_late_latch();
        do_latch(1'b0, 8'd7, 10'd9, 1'b0, 4'd4, 1'b1);
        sync_pulse();
        repeat (3) @(negedge clk);
        chk_act("R10", 8'd3, 10'd4, 1'b1, 4'd4, 1'b1);
        do_latch(1'b0, 8'd8, 10'd12, 1'b1, 4'd11, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10", "stage2", 32'(stage2_o), 1);
        chk_act("R10", 8'd8, 10'd12, 1'b1, 4'd11, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_act("R1", 8'd0, 10'd0, 1'b0, 4'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_on();
        t_steady_on();
        t_disable();
        t_no_latch();
        t_initial();
        t_restart();
        t_lengths();
        t_late_latch();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule